// File: doc/BRIEF.md
# Eight-Digit Dot-Matrix Refresh Multiplexer

This block drives an eight-digit LED array in which every digit is a matrix of 5 columns by 7 rows. The digits form two banks of four. The block scans one row of one bank per display cycle, so it drives 20 column lines at a time. The two banks together have 14 rows, and one full refresh therefore takes 14 display cycles. For every cycle it reads the character codes of the four digits it will show next, one code per refresh tick. A code is either a 7-bit font index, which goes to an external combinational font lookup, or a reference to a user-defined glyph, whose dots come from a separate pattern RAM.

Each display cycle lasts 16 refresh ticks. The first tick is always dark, so that the row and column changes settle before any LED is driven. The other 15 ticks form the on-time window, and a 3-bit brightness code shortens that window. A free-running timebase counts ticks, and its top bit is the slow flash phase. Two settings use it. Per-digit flash darkens the digits whose flash bit is set. Blink darkens the whole array. Both take effect during the low half of the phase.

The refresh tick comes either from an internal divider of the system clock or from rising edges on an external clock pin. The external pin lets several arrays run from one shared timebase.

Top module: `dmx_refresh`

## Requirements
- R1: While reset is held, row_en is 14'h0001 and col_out is zero. Reset clears the tick divider, the scan position and the timebase.
- R2: row_en is one-hot, and bit index = bank*7 + row. The index advances by one every 16 refresh ticks and wraps from 13 to 0.
- R3: col_out bit d*5+c carries dot column c of digit bank*4+d for the current row. For a code with bit 7 = 0, the dots are font_dots for font_code = code[6:0] and font_row = row. For a code with bit 7 = 1, the dots are udc_dots at udc_addr = {code[3:0], row}.
- R4: The columns shown in a display cycle are fetched during the preceding cycle. The first cycle after reset shows all columns off.
- R5: Tick 0 of every display cycle drives all columns off, and row_en changes only at the start of tick 0.
- R6: The columns are lit in ticks 1..N of a cycle. N is 15, 12, 8, 6, 4, 3, 2 and 0 for brightness codes 0 to 7.
- R7: When flash_en = 1 and flash_bits[bank*4+d] = 1, digit d of the bank is dark while the flash phase is low.
- R8: When blink = 1, all columns are dark while the flash phase is low.
- R9: The flash phase is bit TB_W-1 of the count of refresh ticks since reset.
- R10: With clk_sel = 1, a refresh tick occurs every TICK_DIV clocks. With clk_sel = 0, each rising edge of ext_clk gives one tick, and the internal divider has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1: internal divider, 0: external tick clock |
| ext_clk | input | 1 | External refresh clock, synchronised inside |
| bright | input | 3 | Brightness code, 0 brightest, 7 off |
| flash_en | input | 1 | Enables per-digit flashing |
| blink | input | 1 | Blinks the whole array |
| flash_bits | input | 8 | Flash flag per digit |
| char_addr | output | 3 | Character RAM read address (digit) |
| char_data | input | 8 | Character code read back |
| font_code | output | 7 | Font lookup code |
| font_row | output | 3 | Font lookup row |
| font_dots | input | 5 | Font lookup result, bit c = column c |
| udc_addr | output | 7 | User-glyph RAM address {glyph, row} |
| udc_dots | input | 5 | User-glyph row dots |
| row_en | output | 14 | One-hot row enable, bank*7+row |
| col_out | output | 20 | Column drive, digit d at bits d*5+4..d*5 |

## Verification
The latencies differ by result. Brightness, flash and blink gating is combinational on registered scan state, so it is visible in the same tick. Character contents appear one display cycle after they are fetched, and ext_clk edges take effect two to three clocks later. The bench aligns itself to the row change it observes at the ports. It then samples tick k at k*TICK_DIV clocks plus half a clock after that edge, so no sample falls on a register update. When it rewrites the character RAM, it does so in tick 0 and skips the cycle that is already showing the old contents. It derives the flash phase from the number of row changes since reset.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int BANKS   = 2;
  localparam int DPB     = 4;
  localparam int ROWS    = 7;
  localparam int COLS    = 5;
  localparam int DIGITS  = BANKS * DPB;
  localparam int CYCLES  = BANKS * ROWS;
  localparam int COLW    = DPB * COLS;
  localparam int TICKW   = 4;
  localparam int CYCW    = $clog2(CYCLES);
  localparam int ROWW    = $clog2(ROWS);

  // on-time window length in ticks (of 15) per brightness code
  function automatic logic [TICKW-1:0] on_ticks(input logic [2:0] lvl);
    case (lvl)
      3'd0:    on_ticks = 4'd15;
      3'd1:    on_ticks = 4'd12;
      3'd2:    on_ticks = 4'd8;
      3'd3:    on_ticks = 4'd6;
      3'd4:    on_ticks = 4'd4;
      3'd5:    on_ticks = 4'd3;
      3'd6:    on_ticks = 4'd2;
      default: on_ticks = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/dmx_tick_gen.sv
module dmx_tick_gen #(
  parameter int TICK_DIV = 4,
  parameter int TB_W     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_sel,
  input  logic ext_clk,
  output logic tick,
  output logic phase
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0]   div_q, div_d;
  logic [2:0]      ext_q, ext_d;
  logic [TB_W-1:0] tb_q, tb_d;
  logic            int_tick, ext_rise;

  always_comb begin
    int_tick = (div_q == DW'(TICK_DIV - 1));
    ext_rise = ext_q[1] & ~ext_q[2];
    tick     = clk_sel ? int_tick : ext_rise;
    div_d    = int_tick ? '0 : div_q + DW'(1);
    ext_d    = {ext_q[1:0], ext_clk};
    tb_d     = tick ? tb_q + TB_W'(1) : tb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= '0;
      tb_q  <= '0;
    end else begin
      div_q <= div_d;
      ext_q <= ext_d;
      tb_q  <= tb_d;
    end
  end

  assign phase = tb_q[TB_W-1];

  a_r10_int_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel && tick) |=> (!clk_sel || !tick));
  a_r10_ext_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel && tick) |=> (clk_sel || !tick));
  a_r9_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tb_q == $past(tb_q) + TB_W'(1)));
  a_r9_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tb_q));
endmodule

// File: rtl/dmx_scan_fetch.sv
module dmx_scan_fetch
  import dmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [2:0]        char_addr,
  input  logic [7:0]        char_data,
  output logic [6:0]        font_code,
  output logic [ROWW-1:0]   font_row,
  input  logic [COLS-1:0]   font_dots,
  output logic [6:0]        udc_addr,
  input  logic [COLS-1:0]   udc_dots,
  output logic [CYCW-1:0]   cyc,
  output logic [TICKW-1:0]  tcnt,
  output logic [COLW-1:0]   shown
);
  localparam logic [CYCW-1:0]  CYC_LAST  = CYCW'(CYCLES - 1);
  localparam logic [TICKW-1:0] TICK_LAST = '1;

  logic [CYCW-1:0]  cyc_q, cyc_d, nxt;
  logic [TICKW-1:0] tcnt_q, tcnt_d;
  logic [COLW-1:0]  shad_q, shad_d, shown_q, shown_d;
  logic             nbank, fetching, wrap;
  logic [ROWW-1:0]  nrow;
  logic [1:0]       fdig;
  logic [COLS-1:0]  dots;

  always_comb begin
    nxt       = (cyc_q == CYC_LAST) ? '0 : cyc_q + CYCW'(1);
    nbank     = (nxt >= CYCW'(ROWS));
    nrow      = nbank ? ROWW'(nxt - CYCW'(ROWS)) : ROWW'(nxt);
    fetching  = (tcnt_q >= TICKW'(1)) && (tcnt_q <= TICKW'(DPB));
    fdig      = 2'(tcnt_q - TICKW'(1));
    wrap      = tick && (tcnt_q == TICK_LAST);
    char_addr = {nbank, fdig};
    font_code = char_data[6:0];
    font_row  = nrow;
    udc_addr  = {char_data[3:0], nrow};
    dots      = char_data[7] ? udc_dots : font_dots;

    tcnt_d  = tick ? tcnt_q + TICKW'(1) : tcnt_q;
    cyc_d   = wrap ? nxt : cyc_q;
    shown_d = wrap ? shad_q : shown_q;
    shad_d  = shad_q;
    if (tick && fetching) shad_d[fdig*COLS +: COLS] = dots;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      tcnt_q  <= '0;
      shad_q  <= '0;
      shown_q <= '0;
    end else begin
      cyc_q   <= cyc_d;
      tcnt_q  <= tcnt_d;
      shad_q  <= shad_d;
      shown_q <= shown_d;
    end
  end

  assign cyc   = cyc_q;
  assign tcnt  = tcnt_q;
  assign shown = shown_q;

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tcnt_q == TICK_LAST && cyc_q == CYC_LAST) |=> (cyc_q == '0));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cyc_q));
  a_r4_load_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shown_q) |-> $past(tick && tcnt_q == TICK_LAST));
endmodule

// File: rtl/dmx_refresh.sv
module dmx_refresh
  import dmx_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int TB_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_sel,
  input  logic        ext_clk,
  input  logic [2:0]  bright,
  input  logic        flash_en,
  input  logic        blink,
  input  logic [7:0]  flash_bits,
  output logic [2:0]  char_addr,
  input  logic [7:0]  char_data,
  output logic [6:0]  font_code,
  output logic [2:0]  font_row,
  input  logic [4:0]  font_dots,
  output logic [6:0]  udc_addr,
  input  logic [4:0]  udc_dots,
  output logic [13:0] row_en,
  output logic [19:0] col_out
);
  logic [1:0]       rs_q;
  logic             rst_i_n, tick, phase, bank, win, dark_all;
  logic [CYCW-1:0]  cyc;
  logic [TICKW-1:0] tcnt;
  logic [COLW-1:0]  shown;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  dmx_tick_gen #(.TICK_DIV(TICK_DIV), .TB_W(TB_W)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
    .tick(tick), .phase(phase));

  dmx_scan_fetch u_scan (
    .clk(clk), .rst_n(rst_i_n), .tick(tick),
    .char_addr(char_addr), .char_data(char_data),
    .font_code(font_code), .font_row(font_row), .font_dots(font_dots),
    .udc_addr(udc_addr), .udc_dots(udc_dots),
    .cyc(cyc), .tcnt(tcnt), .shown(shown));

  always_comb begin
    bank     = (cyc >= CYCW'(ROWS));
    win      = (tcnt != '0) && (tcnt <= on_ticks(bright));
    dark_all = blink && !phase;
    row_en   = 14'(1) << cyc;
  end

  for (genvar d = 0; d < DPB; d++) begin : g_dig
    localparam logic [1:0] DI = 2'(d);
    logic dig_dark;
    assign dig_dark = flash_en && flash_bits[{bank, DI}] && !phase;
    assign col_out[d*COLS +: COLS] =
      (win && !dark_all && !dig_dark) ? shown[d*COLS +: COLS] : '0;
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(row_en) == 1);
  a_r5_blank_on_row_change: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(row_en) |-> (col_out == '0));
  a_r8_blink_dark: assert property (@(posedge clk) disable iff (!rst_i_n)
    (blink && !phase) |-> (col_out == '0));
  a_r6_level7_off: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bright == 3'd7) |-> (col_out == '0));
endmodule

// File: tb/dmx_refresh_test.sv
`timescale 1ns/1ps
module dmx_refresh_test;
  localparam int TICK_DIV = 2;
  localparam int TB_W     = 6;

  logic        clk = 1'b0;
  logic        rst_n, clk_sel, ext_clk, flash_en, blink;
  logic [2:0]  bright;
  logic [7:0]  flash_bits;
  logic [2:0]  char_addr;
  logic [7:0]  char_data;
  logic [6:0]  font_code;
  logic [2:0]  font_row;
  logic [4:0]  font_dots;
  logic [6:0]  udc_addr;
  logic [4:0]  udc_dots;
  logic [13:0] row_en;
  logic [19:0] col_out;
  logic [7:0]  char_mem [8];

  int checks = 0;
  int fails  = 0;
  int nb     = 0;

  always #2.5 clk = ~clk;

  function automatic logic [4:0] font_f(input logic [6:0] code, input logic [2:0] row);
    return 5'((int'(code) * 7 + int'(row) * 13 + (int'(code) >> 3)) & 31);
  endfunction
  function automatic logic [4:0] udc_f(input logic [6:0] a);
    return 5'((int'(a) * 11 + 5) & 31) ^ 5'h15;
  endfunction
  function automatic int on_n(input logic [2:0] b);
    case (b)
      3'd0: return 15; 3'd1: return 12; 3'd2: return 8; 3'd3: return 6;
      3'd4: return 4;  3'd5: return 3;  3'd6: return 2; default: return 0;
    endcase
  endfunction

  assign char_data = char_mem[char_addr];
  assign font_dots = font_f(font_code, font_row);
  assign udc_dots  = udc_f(udc_addr);

  dmx_refresh #(.TICK_DIV(TICK_DIV), .TB_W(TB_W)) uut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
    .bright(bright), .flash_en(flash_en), .blink(blink), .flash_bits(flash_bits),
    .char_addr(char_addr), .char_data(char_data),
    .font_code(font_code), .font_row(font_row), .font_dots(font_dots),
    .udc_addr(udc_addr), .udc_dots(udc_dots),
    .row_en(row_en), .col_out(col_out));

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // expected column drive for cycle c, tick k, phase ph
  function automatic logic [19:0] exp_col(input int c, input int k, input bit ph);
    logic [19:0] r = '0;
    int b = c / 7;
    int row = c % 7;
    for (int d = 0; d < 4; d++) begin
      logic [7:0] code = char_mem[b*4+d];
      logic [4:0] dots = code[7] ? udc_f({code[3:0], 3'(row)}) : font_f(code[6:0], 3'(row));
      bit lit = (k != 0) && (k <= on_n(bright)) && !(blink && !ph)
                && !(flash_en && flash_bits[b*4+d] && !ph);
      if (lit) r[d*5 +: 5] = dots;
    end
    return r;
  endfunction

  task automatic wait_boundary();
    logic [13:0] prev = row_en;
    do @(negedge clk); while (row_en == prev);
    nb++;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 8; i++) char_mem[i] = 8'($urandom);
    char_mem[1][7] = 1'b1;
    char_mem[6][7] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; clk_sel = 1'b1; ext_clk = 1'b0; bright = 3'd0;
    flash_en = 1'b0; blink = 1'b0; flash_bits = '0;
    fill_mem();
    repeat (3) @(negedge clk);
    chk("R1 row_en in reset", 32'(row_en), 32'h1);
    chk("R1 col_out in reset", 32'(col_out), 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 first cycle blank", 32'(col_out), 32'h0);

    for (int it = 0; it < 70; it++) begin
      int c, k;
      bit ph, skip;
      string tag;
      wait_boundary();
      c  = nb % 14;
      ph = ((nb >> 1) & 1) != 0;
      chk("R2 row index", 32'(row_en), 32'(14'(1) << c));
      chk("R5 tick0 dark", 32'(col_out), 32'h0);
      skip = 1'b0;
      if (it % 12 == 11) begin fill_mem(); skip = 1'b1; end
      case (it)
        1: begin bright = 3'd0; flash_en = 0; blink = 0; k = 15; end
        2: begin bright = 3'd1; flash_en = 0; blink = 0; k = 12; end
        3: begin bright = 3'd1; flash_en = 0; blink = 0; k = 13; end
        4: begin bright = 3'd7; flash_en = 0; blink = 0; k = 1;  end
        5: begin bright = 3'd6; flash_en = 0; blink = 0; k = 2;  end
        default: begin
          bright     = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
          flash_en   = ($urandom % 3 == 0);
          blink      = ($urandom % 4 == 0);
          flash_bits = 8'($urandom);
          k          = 1 + int'($urandom % 15);
        end
      endcase
      repeat (k * TICK_DIV) @(negedge clk);
      if (!skip) begin
        if (blink && !ph) tag = "R8 R9 blink";
        else if (flash_en && !ph && (flash_bits[(c/7)*4 +: 4] != 0)) tag = "R7 R9 flash";
        else if (k > on_n(bright)) tag = "R6 duty";
        else tag = "R3 R4 R6 columns";
        chk(tag, 32'(col_out), 32'(exp_col(c, k, ph)));
      end
    end

    // external tick source
    rst_n = 1'b0; clk_sel = 1'b0; bright = 3'd0; blink = 0; flash_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10 internal ignored", 32'(row_en), 32'h1);
    for (int p = 0; p < 15; p++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R10 15 ext ticks", 32'(row_en), 32'h1);
    ext_clk = 1'b1; repeat (3) @(negedge clk);
    ext_clk = 1'b0; repeat (6) @(negedge clk);
    chk("R10 16 ext ticks", 32'(row_en), 32'h2);
    chk("R5 R10 tick0 dark", 32'(col_out), 32'h0);
    report();
  end
endmodule